// File: doc/BRIEF.md
# Aging-Aware One/Two-Cycle Hold Controller

This block sits beside a bypassing multiplier and decides, for every operand pair it accepts, whether the product can settle within one clock cycle or needs two. It counts the zero bits in one operand (the multiplicand for a column-bypassing datapath, the multiplier for a row-bypassing one) and compares that count with a threshold. An operation classed as two-cycle stalls the input registers for one extra cycle through the `hold` output.

Timing errors from the Razor-style product registers come in as a one-cycle pulse on `razor_err`. When a one-cycle operation turns out to be wrong, the block stalls the inputs for two cycles so that the operation is replayed with double time. Errors are counted over a window of accepted operations. Once enough errors fall inside one window, a sticky aging flag is set. From then on the decision uses a stricter zero-count threshold, so fewer operations are trusted to finish in one cycle.

Top module: `aging_hold_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and right after it, `hold` and `aging_flag` are 0.
- R2: With ROW_MODE=0 only the zeros of `op_a` decide the class, and `op_b` has no effect. With ROW_MODE=1 only the zeros of `op_b` decide it.
- R3: While `aging_flag` is 0, an accepted operation is one-cycle exactly when its judged operand has at least ZC0 zero bits.
- R4: While `aging_flag` is 1, an accepted operation is one-cycle exactly when its judged operand has at least ZC1 zero bits (ZC1 > ZC0).
- R5: An operation is accepted at a rising edge where `op_valid`=1 and `hold`=0. A two-cycle operation holds `hold` high for exactly the one cycle that follows its acceptance. A one-cycle operation that is free of errors leaves `hold` low.
- R6: A `razor_err` pulse in the cycle right after a one-cycle acceptance raises `hold` in that same cycle and in the next cycle (a two-cycle replay), and counts as one timing error.
- R7: A `razor_err` pulse at any other time raises no `hold` and is not counted.
- R8: `aging_flag` rises in the cycle after the ERR_LIM-th counted error within one window of WIN_OPS accepted operations.
- R9: The error count clears when the WIN_OPS-th operation of a window is accepted. Once set, `aging_flag` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operand pair is presented |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| razor_err | input | 1 | Timing-error pulse from the product registers |
| hold | output | 1 | Stall for the input registers; an operation is accepted only while low |
| aging_flag | output | 1 | Sticky flag: stricter criterion in force |

## Verification
Every 8-bit multiplicand value is swept once before aging and once after it, with the other operand held at zero. This tells the ZC0 threshold apart from the ZC1 threshold at every zero count, and it shows that the unused operand has no influence. A row-mode instance is swept over its multiplier with the multiplicand at zero, which separates the two operand choices. The error tests first place three errors in one window and one in the next, which must not set the flag, and then place four inside one window, which must set it. Error pulses that come during a two-cycle hold or while the block is idle are injected before these sequences; if such a pulse were counted, the flag would rise early.

// File: rtl/ahl_pkg.sv
package ahl_pkg;

    // Registered decision state of the controller (the decision flip-flop
    // together with the replay stage).
    typedef struct packed {
        logic two_pend;   // a two-cycle operation was accepted last cycle
        logic one_pend;   // a one-cycle operation was accepted last cycle
        logic replay;     // second cycle of an error replay
    } ahl_state_t;

    typedef enum logic {
        CLS_ONE = 1'b0,
        CLS_TWO = 1'b1
    } op_class_e;

    function automatic op_class_e pick_class(input logic aged,
                                             input logic fast_lo,
                                             input logic fast_hi);
        logic fast;
        fast = aged ? fast_hi : fast_lo;
        return fast ? CLS_ONE : CLS_TWO;
    endfunction

endpackage

// File: rtl/ahl_judge.sv
module ahl_judge #(
    parameter int W    = 8,
    parameter int ZMIN = 3
) (
    input  logic [W-1:0] opnd,
    output logic         fast
);
    localparam int ZW = $clog2(W + 1);

    logic [ZW-1:0] zeros;

    always_comb begin
        zeros = '0;
        for (int i = 0; i < W; i++) begin
            if (!opnd[i]) zeros = zeros + ZW'(1);
        end
        fast = (int'(zeros) >= ZMIN);
    end
endmodule

// File: rtl/ahl_aging_mon.sv
module ahl_aging_mon #(
    parameter int WIN_OPS = 16,
    parameter int ERR_LIM = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic op_accept,
    input  logic err_hit,
    output logic aged
);
    localparam int OCW = (WIN_OPS > 1) ? $clog2(WIN_OPS) : 1;
    localparam int ECW = $clog2(ERR_LIM + 1);

    logic [OCW-1:0] op_cnt;
    logic [ECW-1:0] err_cnt;
    logic           win_end;
    logic           lim_hit;

    always_comb begin
        win_end = op_accept && (op_cnt == OCW'(WIN_OPS - 1));
        lim_hit = err_hit && (err_cnt == ECW'(ERR_LIM - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_cnt  <= '0;
            err_cnt <= '0;
            aged    <= 1'b0;
        end else begin
            if (op_accept) begin
                op_cnt <= win_end ? '0 : op_cnt + OCW'(1);
            end
            if (win_end) begin
                err_cnt <= '0;
            end else if (err_hit) begin
                err_cnt <= lim_hit ? '0 : err_cnt + ECW'(1);
            end
            if (lim_hit) begin
                aged <= 1'b1;
            end
        end
    end

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        aged |=> aged);
    a_r8_rise_after_error: assert property (@(posedge clk) disable iff (rst)
        $rose(aged) |-> $past(err_hit));
    a_r9_window_bounded: assert property (@(posedge clk) disable iff (rst)
        int'(op_cnt) < WIN_OPS);
    a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
        int'(err_cnt) < ERR_LIM);
endmodule

// File: rtl/aging_hold_ctrl.sv
module aging_hold_ctrl
    import ahl_pkg::*;
#(
    parameter int W        = 8,
    parameter int ZC0      = 3,
    parameter int ZC1      = 5,
    parameter int WIN_OPS  = 16,
    parameter int ERR_LIM  = 4,
    parameter bit ROW_MODE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         razor_err,
    output logic         hold,
    output logic         aging_flag
);
    logic [W-1:0] judged;
    logic         fast_lo, fast_hi;
    logic         aged;
    logic         accept, err_hit;
    op_class_e    cls;
    ahl_state_t   st_q, st_d;

    generate
        if (ROW_MODE) begin : g_row
            assign judged = op_b;
        end else begin : g_col
            assign judged = op_a;
        end
    endgenerate

    ahl_judge #(.W(W), .ZMIN(ZC0)) u_judge_lo (.opnd(judged), .fast(fast_lo));
    ahl_judge #(.W(W), .ZMIN(ZC1)) u_judge_hi (.opnd(judged), .fast(fast_hi));

    always_comb begin
        cls     = pick_class(aged, fast_lo, fast_hi);
        err_hit = st_q.one_pend & razor_err;
        hold    = st_q.two_pend | st_q.replay | err_hit;
        accept  = op_valid & ~hold;
        st_d.two_pend = accept & (cls == CLS_TWO);
        st_d.one_pend = accept & (cls == CLS_ONE);
        st_d.replay   = err_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    ahl_aging_mon #(.WIN_OPS(WIN_OPS), .ERR_LIM(ERR_LIM)) u_mon (
        .clk      (clk),
        .rst      (rst),
        .op_accept(accept),
        .err_hit  (err_hit),
        .aged     (aged)
    );

    assign aging_flag = aged;

    a_r5_two_cycle_single: assert property (@(posedge clk) disable iff (rst)
        st_q.two_pend |=> !hold);
    a_r6_replay_second_cycle: assert property (@(posedge clk) disable iff (rst)
        err_hit |=> hold);
    a_r7_stray_error_ignored: assert property (@(posedge clk) disable iff (rst)
        (razor_err && !st_q.one_pend && !st_q.two_pend && !st_q.replay) |-> !hold);
    a_r4_strict_implies_loose: assert property (@(posedge clk) disable iff (rst)
        fast_hi |-> fast_lo);
endmodule

// File: tb/aging_hold_ctrl_bench.sv
module aging_hold_ctrl_bench;
    localparam int W = 8, ZC0 = 3, ZC1 = 5, WIN = 16, LIM = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0, razor_err = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic hold, aging_flag;
    logic r_valid = 1'b0;
    logic [W-1:0] r_a = '0, r_b = '0;
    logic r_err = 1'b0;
    logic hold_r, aging_r;

    int n_tests = 0, n_fail = 0;
    int m_ops = 0, m_errs = 0;
    bit m_aged = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    aging_hold_ctrl #(.W(W), .ZC0(ZC0), .ZC1(ZC1), .WIN_OPS(WIN), .ERR_LIM(LIM),
                      .ROW_MODE(1'b0)) u_aging_hold_ctrl (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
        .razor_err(razor_err), .hold(hold), .aging_flag(aging_flag));

    aging_hold_ctrl #(.W(W), .ZC0(ZC0), .ZC1(ZC1), .WIN_OPS(WIN), .ERR_LIM(LIM),
                      .ROW_MODE(1'b1)) u_aging_hold_ctrl_row (
        .clk(clk), .rst(rst), .op_valid(r_valid), .op_a(r_a), .op_b(r_b),
        .razor_err(r_err), .hold(hold_r), .aging_flag(aging_r));

    function automatic int zcount(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) n += (v[i] == 1'b0) ? 1 : 0;
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after a falling edge.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit inj);
        bit fast;
        op_a = a; op_b = b; op_valid = 1'b1;
        #1 chk(hold == 1'b0, "R5 idle before accept", hold, 0);
        @(negedge clk);
        op_valid = 1'b0;
        fast = zcount(a) >= (m_aged ? ZC1 : ZC0);
        m_ops++;
        if (m_ops == WIN) begin m_ops = 0; m_errs = 0; end
        chk(hold == !fast, m_aged ? "R4 class after aging" : "R3 class before aging",
            hold, !fast);
        if (!fast) begin
            @(negedge clk);
            chk(hold == 1'b0, "R5 hold lasts one cycle", hold, 0);
        end else if (inj) begin
            razor_err = 1'b1;
            #1 chk(hold == 1'b1, "R6 hold on error", hold, 1);
            @(negedge clk);
            razor_err = 1'b0;
            m_errs++;
            if (m_errs == LIM) m_aged = 1'b1;
            chk(hold == 1'b1, "R6 replay second cycle", hold, 1);
            chk(aging_flag == m_aged, "R8 flag after error", aging_flag, m_aged);
            @(negedge clk);
            chk(hold == 1'b0, "R6 replay ends", hold, 0);
        end
    endtask

    task automatic run_row(input logic [W-1:0] b);
        bit fast;
        r_a = '0; r_b = b; r_valid = 1'b1;
        @(negedge clk);
        r_valid = 1'b0;
        fast = zcount(b) >= ZC0;
        chk(hold_r == !fast, "R2 row mode judges op_b", hold_r, !fast);
        if (!fast) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 chk(hold == 1'b0, "R1 hold in reset", hold, 0);
        chk(aging_flag == 1'b0, "R1 flag in reset", aging_flag, 0);
        @(negedge clk);
        rst = 1'b0;
        #1 chk(hold == 1'b0 && aging_flag == 1'b0, "R1 after reset", hold, 0);

        // R2/R3: every multiplicand, multiplier all zeros (ignored in column mode)
        for (int v = 0; v < 256; v++) run_op(W'(v), '0, 1'b0);

        // R2: row-mode instance judges the multiplier
        for (int v = 0; v < 256; v++) run_row(W'(v));

        // align to a window start
        while (m_ops != 0) run_op(8'hFF, 8'h00, 1'b0);

        // R7: error during a two-cycle hold and while idle must be ignored
        op_a = 8'hFF; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; m_ops++;
        razor_err = 1'b1;
        #1 chk(hold == 1'b1, "R5 two-cycle hold", hold, 1);
        @(negedge clk);
        chk(hold == 1'b0, "R7 no replay for stray error", hold, 0);
        @(negedge clk);
        #1 chk(hold == 1'b0, "R7 idle error no hold", hold, 0);
        razor_err = 1'b0;

        // R9: three errors, then cross a window boundary, then one more
        for (int k = 0; k < LIM - 1; k++) run_op(8'h00, 8'hFF, 1'b1);
        chk(aging_flag == 1'b0, "R8 below threshold", aging_flag, 0);
        while (m_ops != 0) run_op(8'hFF, 8'h00, 1'b0);
        run_op(8'h00, 8'hFF, 1'b1);
        chk(aging_flag == 1'b0, "R9 count cleared at window", aging_flag, 0);

        // R8: reach the threshold within the window
        for (int k = 0; k < LIM - 1; k++) run_op(8'h00, 8'hFF, 1'b1);
        chk(aging_flag == 1'b1, "R8 flag set at threshold", aging_flag, 1);

        // R4: every multiplicand with the strict criterion; R9 flag stays set
        for (int v = 0; v < 256; v++) run_op(W'(v), '0, 1'b0);
        chk(aging_flag == 1'b1, "R9 flag sticky across windows", aging_flag, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule